// File: doc/BRIEF.md
# Execute-Stage ALU with Status Register and Constant Source

This block is the arithmetic stage of a small 16-bit RISC core. Each cycle in which `ex_valid` is high it takes a source operand and a destination operand. It performs one of six operations (add, subtract, compare, AND, OR, XOR) at byte or word width. It then registers the result, zero-extended to the 20-bit register width, together with a one-cycle write strobe. The status register is kept inside the block. The carry, zero, negative and overflow flags are updated from the operation. The interrupt-enable bit and the power-control bits are left for the core to load through `sr_load`.

The source operand does not always come from the register file. When the source register number is 2 or 3, the 2-bit source mode selects a fixed constant in place of the register read. The one exception is register 2 in mode 00, which returns the status register itself. Increment, decrement and clear therefore need no dedicated opcodes.

Top module: `exec_alu`

## Requirements
- R1: While reset is asserted, and after its synchronous release, `res_out`, `res_wr` and `sr_out` are all zero.
- R2: Opcode 0 adds (dst + src) and opcode 1 subtracts (dst - src). The result is taken at the selected width. Carry (SR bit 0) is the carry out of the top bit for add and means "no borrow" (dst >= src unsigned) for subtract.
- R3: Overflow (SR bit 8) is set exactly when the signed add or subtract result falls outside the signed range of the selected width.
- R4: Negative (SR bit 2) equals the top bit of the result and zero (SR bit 1) is set when the result is zero. Both are taken at bit 7 and bits 7:0 in byte mode (`ex_byte`=1) and at bit 15 and bits 15:0 in word mode. Operand bits above the selected width have no effect.
- R5: Compare (opcode 2) sets the flags exactly as subtract does. It leaves `res_wr` low and `res_out` unchanged.
- R6: AND, OR and XOR (opcodes 3, 4, 5) write the bitwise result, set N and Z as in R4, clear V and set C to the inverse of Z.
- R7: With source register 3, modes 00, 01, 10 and 11 supply 0, +1, +2 and all ones (-1) as the source operand.
- R8: With source register 2, mode 00 supplies the current status register, mode 01 supplies 0, mode 10 supplies 4 and mode 11 supplies 8.
- R9: A byte write places the result in `res_out[7:0]` with bits 19:8 zero. A word write places it in bits 15:0 with bits 19:16 zero. `res_wr` pulses in the cycle after any accepted opcode 0, 1, 3, 4 or 5.
- R10: ALU operations change only SR bits 8, 2, 1 and 0. Interrupt enable (bit 3), power-control bits 7:4 and bits 15:9 keep their value.
- R11: Opcodes 6 and 7 are inert: no write strobe, no result change, no status change.
- R12: `sr_load` writes `sr_din` into the whole status register on the next edge and takes priority over a flag update in the same cycle.
- R13: With `ex_valid` low and no `sr_load`, the result, the strobe and the status register do not change (the strobe stays low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ex_valid | input | 1 | Operation valid this cycle |
| ex_op | input | 3 | Opcode: 0 add, 1 sub, 2 cmp, 3 and, 4 or, 5 xor, 6/7 none |
| ex_byte | input | 1 | 1 selects byte width, 0 word width |
| src_reg | input | 4 | Source register number |
| src_mode | input | 2 | Source addressing-mode bits |
| src_val | input | 16 | Source register read value |
| dst_val | input | 16 | Destination operand value |
| sr_load | input | 1 | Load the status register from `sr_din` |
| sr_din | input | 16 | Status register load value |
| res_out | output | 20 | Registered, zero-extended result |
| res_wr | output | 1 | Result write strobe, one cycle |
| sr_out | output | 16 | Status register |

## Verification
The bench goes after the width boundaries where carry and overflow diverge. These are 0x7FFF+1, 0x8000-1, 0-1 and 0xFFFF+1 in word mode, and their 0x7F/0x80 counterparts in byte mode with stray upper operand bits. A design that took byte flags from bit 15 would report wrong N, C and V there and would see a non-zero Z. Each constant-generator code is applied once, including register 2 in mode 00 after a status load. A generator that confused the two constant registers, or fed the register read through for modes 01 to 11, shows up as a wrong sum. Further directed vectors cover a compare that must not strobe a write, reserved opcodes, a status load colliding with a flag update, and logic results whose carry must follow the inverse of zero. These are mixed with seeded random vectors.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  // status register bit positions
  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_N  = 2;
  localparam int FLG_IE = 3;
  localparam int FLG_V  = 8;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_const_gen.sv
module alu_const_gen #(
  parameter int DW      = 16,
  parameter int RNUM_W  = 4,
  parameter int SR_IDX  = 2,
  parameter int CG_IDX  = 3
) (
  input  logic [RNUM_W-1:0] src_reg,
  input  logic [1:0]        src_mode,
  input  logic [DW-1:0]     src_val,
  input  logic [DW-1:0]     sr_val,
  output logic [DW-1:0]     operand
);
  localparam logic [RNUM_W-1:0] SR_NUM = RNUM_W'(SR_IDX);
  localparam logic [RNUM_W-1:0] CG_NUM = RNUM_W'(CG_IDX);

  always_comb begin
    operand = src_val;
    if (src_reg == CG_NUM) begin
      unique case (src_mode)
        2'b00: operand = '0;
        2'b01: operand = DW'(1);
        2'b10: operand = DW'(2);
        default: operand = '1;
      endcase
    end else if (src_reg == SR_NUM) begin
      unique case (src_mode)
        2'b00: operand = sr_val;
        2'b01: operand = '0;
        2'b10: operand = DW'(4);
        default: operand = DW'(8);
      endcase
    end
  end

  // R8: status-register constants are zero or a single power of two
  always_comb begin
    if (src_reg == SR_NUM && src_mode != 2'b00)
      assert_sr_const_sparse_R8: assert ($countones(operand) <= 1);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  alu_op_e      op,
  input  logic         byte_mode,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] dst,
  output logic [DW-1:0] res,
  output alu_flags_t   flags,
  output logic         upd,
  output logic         wr
);
  logic          is_sub, is_arith;
  logic [DW-1:0] src_x;
  logic [DW:0]   sum_w;
  logic [BW:0]   sum_b;
  logic [DW-1:0] lres;
  logic          res_msb, dst_msb, srcx_msb;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_CMP);
    is_arith = is_sub || (op == OP_ADD);
    src_x    = is_sub ? ~src : src;
    sum_w    = {1'b0, dst} + {1'b0, src_x} + {{DW{1'b0}}, is_sub};
    sum_b    = {1'b0, dst[BW-1:0]} + {1'b0, src_x[BW-1:0]} + {{BW{1'b0}}, is_sub};

    unique case (op)
      OP_AND:  lres = src & dst;
      OP_OR:   lres = src | dst;
      default: lres = src ^ dst;
    endcase

    if (is_arith) res = byte_mode ? {{(DW-BW){1'b0}}, sum_b[BW-1:0]} : sum_w[DW-1:0];
    else          res = byte_mode ? {{(DW-BW){1'b0}}, lres[BW-1:0]}  : lres;

    res_msb  = byte_mode ? res[BW-1]   : res[DW-1];
    dst_msb  = byte_mode ? dst[BW-1]   : dst[DW-1];
    srcx_msb = byte_mode ? src_x[BW-1] : src_x[DW-1];

    flags.n = res_msb;
    flags.z = (res == '0);
    if (is_arith) begin
      flags.c = byte_mode ? sum_b[BW] : sum_w[DW];
      flags.v = (dst_msb == srcx_msb) && (res_msb != dst_msb);
    end else begin
      flags.c = ~flags.z;
      flags.v = 1'b0;
    end

    upd = (op != OP_RSV6) && (op != OP_RSV7);
    wr  = upd && (op != OP_CMP);
  end
endmodule

// File: rtl/alu_status.sv
module alu_status
  import alu_pkg::*;
#(
  parameter int SRW = 16
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           ld,
  input  logic [SRW-1:0] ld_data,
  input  logic           upd,
  input  alu_flags_t     flags,
  output logic [SRW-1:0] sr_q
);
  logic [SRW-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (ld) begin
      sr_d = ld_data;
    end else if (upd) begin
      sr_d[FLG_V] = flags.v;
      sr_d[FLG_N] = flags.n;
      sr_d[FLG_Z] = flags.z;
      sr_d[FLG_C] = flags.c;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assert_ctl_bits_kept_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !ld |=> ($stable(sr_q[FLG_V-1:FLG_IE]) && $stable(sr_q[SRW-1:FLG_V+1])));

  assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    ld |=> (sr_q == $past(ld_data)));
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import alu_pkg::*;
#(
  parameter int DW       = 16,
  parameter int XW       = 20,
  parameter int BW       = 8,
  parameter int SRW      = 16,
  parameter int RNUM_W   = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_valid,
  input  logic [2:0]        ex_op,
  input  logic              ex_byte,
  input  logic [RNUM_W-1:0] src_reg,
  input  logic [1:0]        src_mode,
  input  logic [DW-1:0]     src_val,
  input  logic [DW-1:0]     dst_val,
  input  logic              sr_load,
  input  logic [SRW-1:0]    sr_din,
  output logic [XW-1:0]     res_out,
  output logic              res_wr,
  output logic [SRW-1:0]    sr_out
);
  localparam int PAD = XW - DW;

  logic          rst_i;
  logic [DW-1:0] src_op, core_res, sr_view;
  alu_flags_t    core_flags;
  logic          core_upd, core_wr;
  logic [XW-1:0] res_q, res_d;
  logic          wr_q, wr_d;

  alu_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  assign sr_view = sr_out[DW-1:0];

  alu_const_gen #(.DW(DW), .RNUM_W(RNUM_W)) u_cg (
    .src_reg(src_reg), .src_mode(src_mode), .src_val(src_val),
    .sr_val(sr_view), .operand(src_op));

  alu_core #(.DW(DW), .BW(BW)) u_core (
    .op(alu_op_e'(ex_op)), .byte_mode(ex_byte), .src(src_op), .dst(dst_val),
    .res(core_res), .flags(core_flags), .upd(core_upd), .wr(core_wr));

  alu_status #(.SRW(SRW)) u_sr (
    .clk(clk), .rst_ni(rst_i), .ld(sr_load), .ld_data(sr_din),
    .upd(ex_valid && core_upd), .flags(core_flags), .sr_q(sr_out));

  always_comb begin
    res_d = res_q;
    wr_d  = 1'b0;
    if (ex_valid && core_wr) begin
      wr_d  = 1'b1;
      res_d = {{PAD{1'b0}}, core_res};
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      res_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      wr_q  <= wr_d;
    end
  end

  assign res_out = res_q;
  assign res_wr  = wr_q;

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (ex_valid && ex_op == 3'd2) |=> (!res_wr && $stable(res_out)));

  assert_rsv_inert_R11: assert property (@(posedge clk) disable iff (!rst_i)
    (ex_valid && ex_op[2:1] == 2'b11 && !sr_load) |=> ($stable(sr_out) && !res_wr));

  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (ex_valid && (ex_op inside {3'd3, 3'd4, 3'd5}) && !sr_load)
      |=> (!sr_out[FLG_V] && (sr_out[FLG_C] == !sr_out[FLG_Z])));

  assert_byte_zext_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (ex_valid && ex_byte && (ex_op inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5}))
      |=> (res_wr && res_out[XW-1:BW] == '0));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_i)
    (!ex_valid && !sr_load) |=> ($stable(sr_out) && $stable(res_out) && !res_wr));
endmodule

// File: tb/sim_exec_alu.sv
module sim_exec_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ex_valid, ex_byte, sr_load;
  logic [2:0]  ex_op;
  logic [3:0]  src_reg;
  logic [1:0]  src_mode;
  logic [15:0] src_val, dst_val, sr_din;
  logic [19:0] res_out;
  logic        res_wr;
  logic [15:0] sr_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [19:0] exp_res = '0;
  logic [15:0] exp_sr  = '0;

  always #10ns clk = ~clk;

  exec_alu u0 (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_op(ex_op),
    .ex_byte(ex_byte), .src_reg(src_reg), .src_mode(src_mode),
    .src_val(src_val), .dst_val(dst_val), .sr_load(sr_load), .sr_din(sr_din),
    .res_out(res_out), .res_wr(res_wr), .sr_out(sr_out));

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic int sx(int x, int w);
    return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
  endfunction

  task automatic apply(string tag, logic v, logic [2:0] op, logic bm, logic [3:0] rg,
                       logic [1:0] md, logic [15:0] sv, logic [15:0] dv,
                       logic ld, logic [15:0] din);
    int w = bm ? 8 : 16;
    int mask = (1 << w) - 1;
    int hi = 1 << (w - 1);
    int a, b, full, r, s;
    bit cf, vf, nf, zf, exp_wr;
    // source operand per R7/R8
    if (rg == 4'd3)      a = (md == 0) ? 0 : (md == 1) ? 1 : (md == 2) ? 2 : 'hFFFF;
    else if (rg == 4'd2) a = (md == 0) ? int'(exp_sr) : (md == 1) ? 0 : (md == 2) ? 4 : 8;
    else                 a = int'(sv);
    a = a & mask;
    b = int'(dv) & mask;
    s = 0; cf = 0;
    case (op)
      3'd0: begin full = a + b; cf = (full > mask); s = sx(a, w) + sx(b, w); end
      3'd1, 3'd2: begin full = b - a; cf = (b >= a); s = sx(b, w) - sx(a, w); end
      3'd3: full = a & b;
      3'd4: full = a | b;
      default: full = a ^ b;
    endcase
    r  = full & mask;
    nf = (r & hi) != 0;
    zf = (r == 0);
    if (op <= 3'd2) vf = (s > hi - 1) || (s < -hi);
    else begin vf = 0; cf = !zf; end
    exp_wr = v && (op inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5});
    if (exp_wr) exp_res = 20'(r);
    if (ld) exp_sr = din;
    else if (v && op <= 3'd5) begin
      exp_sr[8] = vf; exp_sr[2] = nf; exp_sr[1] = zf; exp_sr[0] = cf;
    end
    ex_valid = v; ex_op = op; ex_byte = bm; src_reg = rg; src_mode = md;
    src_val = sv; dst_val = dv; sr_load = ld; sr_din = din;
    @(posedge clk);
    @(negedge clk);
    check(tag, "res_out", 32'(res_out), 32'(exp_res));
    check(tag, "res_wr", 32'(res_wr), 32'(exp_wr));
    check(tag, "sr_out", 32'(sr_out), 32'(exp_sr));
  endtask

  function automatic string auto_tag(logic v, logic [2:0] op, logic [3:0] rg, logic ld);
    if (ld) return "R12";
    if (!v) return "R13";
    if (op[2:1] == 2'b11) return "R11";
    if (rg == 4'd3) return "R7";
    if (rg == 4'd2) return "R8";
    if (op == 3'd2) return "R5";
    if (op >= 3'd3) return "R6";
    return "R2";
  endfunction

  function automatic logic [15:0] pick16();
    case ($urandom % 8)
      0: return 16'h0000;
      1: return 16'h007F;
      2: return 16'h0080;
      3: return 16'h00FF;
      4: return 16'h7FFF;
      5: return 16'h8000;
      6: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ex_valid = 0; ex_op = 0; ex_byte = 0; src_reg = 0; src_mode = 0;
    src_val = 0; dst_val = 0; sr_load = 0; sr_din = 0;
    repeat (3) @(negedge clk);
    check("R1", "res_out in reset", 32'(res_out), 0);
    check("R1", "res_wr in reset", 32'(res_wr), 0);
    check("R1", "sr_out in reset", 32'(sr_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "sr_out after release", 32'(sr_out), 0);
    check("R1", "res_out after release", 32'(res_out), 0);

    // R2 carry out and borrow
    apply("R2", 1, 3'd0, 0, 4'd5, 0, 16'h0001, 16'hFFFF, 0, 0);
    apply("R2", 1, 3'd1, 0, 4'd5, 0, 16'h0001, 16'h0000, 0, 0);
    apply("R2", 1, 3'd1, 0, 4'd6, 0, 16'h1234, 16'h5000, 0, 0);
    // R3 signed overflow at word width
    apply("R3", 1, 3'd0, 0, 4'd7, 0, 16'h0001, 16'h7FFF, 0, 0);
    apply("R3", 1, 3'd1, 0, 4'd7, 0, 16'h0001, 16'h8000, 0, 0);
    // R4 byte width: upper operand bits ignored, flags at bit 7
    apply("R4", 1, 3'd0, 1, 4'd8, 0, 16'hAB80, 16'h1280, 0, 0);
    apply("R4", 1, 3'd0, 1, 4'd8, 0, 16'h0001, 16'h347F, 0, 0);
    // R5 compare: flags only
    apply("R5", 1, 3'd2, 0, 4'd9, 0, 16'h1234, 16'h1234, 0, 0);
    apply("R5", 1, 3'd2, 0, 4'd9, 0, 16'h0002, 16'h0001, 0, 0);
    // R6 logic flags
    apply("R6", 1, 3'd3, 0, 4'd10, 0, 16'h0F0F, 16'hF0F0, 0, 0);
    apply("R6", 1, 3'd5, 0, 4'd10, 0, 16'h0F0F, 16'hF0F0, 0, 0);
    apply("R6", 1, 3'd4, 1, 4'd10, 0, 16'hFF00, 16'h0000, 0, 0);
    // R7 constants from register 3
    for (int m = 0; m < 4; m++) apply("R7", 1, 3'd0, 0, 4'd3, 2'(m), 16'h5555, 16'h0010, 0, 0);
    apply("R7", 1, 3'd0, 1, 4'd3, 2'd3, 16'h5555, 16'h0010, 0, 0);
    // R10/R12 load control bits, concurrent with an add
    apply("R12", 1, 3'd0, 0, 4'd5, 0, 16'h0001, 16'h7FFF, 1, 16'hFEF8);
    apply("R10", 1, 3'd0, 0, 4'd5, 0, 16'h0001, 16'hFFFF, 0, 0);
    apply("R10", 1, 3'd5, 0, 4'd5, 0, 16'h00FF, 16'h00FF, 0, 0);
    // R8 constants from register 2, mode 00 reads the status register
    for (int m = 0; m < 4; m++) apply("R8", 1, 3'd0, 0, 4'd2, 2'(m), 16'h5555, 16'h0100, 0, 0);
    apply("R8", 1, 3'd3, 0, 4'd2, 2'd0, 16'h0000, 16'hFFFF, 0, 0);
    // R9 zero extension
    apply("R9", 1, 3'd4, 1, 4'd4, 0, 16'hFFFF, 16'hFFFF, 0, 0);
    apply("R9", 1, 3'd4, 0, 4'd4, 0, 16'hFFFF, 16'hFFFF, 0, 0);
    // R11 reserved opcodes
    apply("R11", 1, 3'd6, 0, 4'd4, 0, 16'h0001, 16'h0001, 0, 0);
    apply("R11", 1, 3'd7, 1, 4'd4, 0, 16'h0000, 16'h0000, 0, 0);
    // R13 idle
    apply("R13", 0, 3'd0, 0, 4'd4, 0, 16'h0001, 16'h0000, 0, 0);

    for (int i = 0; i < 1500; i++) begin
      logic v, ld, bm;
      logic [2:0] op;
      logic [3:0] rg;
      logic [1:0] md;
      v  = ($urandom % 8) != 0;
      ld = ($urandom % 10) == 0;
      op = 3'($urandom);
      bm = 1'($urandom);
      rg = (($urandom % 4) == 0) ? 4'(2 + ($urandom % 2)) : 4'($urandom);
      md = 2'($urandom);
      apply(auto_tag(v, op, rg, ld), v, op, bm, rg, md, pick16(), pick16(), ld, 16'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule